// File: doc/BRIEF.md
# Slave Register Access Bridge

This block lets a host processor reach a slave register file (for example the registers of a power-management companion chip) through ordinary memory-mapped register accesses. A host store that falls inside the slave window is turned into a slave write. It is placed in a small write queue and then sent out on a request/acknowledge back-end port, one transaction at a time. The host can see whether the queue is full or empty, and a sticky flag records any store that was lost because the queue was full.

A slave read starts when the host stores a slave address into the read-command register. From that edge on, the busy bit of the read-data register is set. The read waits until every queued write has gone out, then runs on the back end. When the acknowledge arrives, busy clears and the read-data register holds the returned value together with an echo of the address that was read. The host compares the echo against the address it asked for. Two echo encodings are available, chosen by a parameter: one for byte-granular and one for word-granular slave addressing.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, be_req is low, the read-data register (offset 0x2C) reads 0, and the queue status register (offset 0x30) reads 0x400, which means empty only.
- R2: A host write of an address below WIN_SIZE to offset 0x28 sets bit 31 (busy) of the read-data register at that clock edge. It then issues a back-end read with be_wr low and be_addr equal to the written address.
- R3: Busy clears at the edge where the back-end read is acknowledged. At that edge bits 15:0 of the read-data register take be_rdata, and bits 30:16 take the echoed address.
- R4: With NEW_MODE=0 the echo is command address bits 14:0. With NEW_MODE=1 it is command address bits 16:2.
- R5: A read command whose address is WIN_SIZE or above leaves busy clear and issues no back-end transaction. WIN_SIZE-1 is accepted.
- R6: A host write to an address from WIN_BASE to WIN_BASE+WIN_SIZE-1 is issued as a back-end write, with be_wr high, be_addr equal to the offset into the window, and be_wdata equal to write data bits 15:0. Writes go out in arrival order. Stores outside the window issue nothing.
- R7: Bit 11 of the status register is set while FIFO_DEPTH writes are waiting or in flight. Bit 10 is set while none are.
- R8: A window write that arrives while the queue is full is dropped and sets status bit 12. That bit stays set until reset.
- R9: Only one back-end transaction is outstanding at a time. be_req stays high with be_wr, be_addr and be_wdata stable until be_ack, and it is low for at least one cycle after each acknowledge.
- R10: A back-end read is issued only when no write is queued or in flight, so writes that were accepted before the read go out first.
- R11: A read command written while busy is set is ignored: the pending address, and the result it produces, are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | HOST_AW | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Register read data for hst_addr (combinational) |
| be_req | output | 1 | Back-end transaction request |
| be_wr | output | 1 | Back-end direction, 1 for write |
| be_addr | output | SLV_AW | Back-end slave address |
| be_wdata | output | DATA_W | Back-end write data |
| be_ack | input | 1 | Back-end acknowledge; completes the transaction |
| be_rdata | input | DATA_W | Back-end read data, valid with be_ack on a read |

## Verification
The bench builds the block twice with FIFO_DEPTH=2, once with each echo mode, and drives both with the same stimulus. A shallow queue can be filled with two stores while a slow acknowledge holds the first one in flight, so the full flag, dropped stores and the sticky overflow bit all come within reach in a few cycles. The second instance exposes the word-granular echo of the same reads. An adjustable acknowledge latency lets a read command land while writes are still draining, and lets a second command arrive while the first read is outstanding.

// File: rtl/pmic_bridge.sv
module pmic_bridge #(
  parameter int HOST_AW    = 16,
  parameter int WIN_BASE   = 'h8000,
  parameter int WIN_SIZE   = 4096,
  parameter int FIFO_DEPTH = 4,
  parameter bit NEW_MODE   = 1'b0,
  parameter int SLV_AW     = 17,
  parameter int DATA_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_we,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  output logic               be_req,
  output logic               be_wr,
  output logic [SLV_AW-1:0]  be_addr,
  output logic [DATA_W-1:0]  be_wdata,
  input  logic               be_ack,
  input  logic [DATA_W-1:0]  be_rdata
);
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int ECHO_W = 15;
  localparam int ENT_W  = SLV_AW + DATA_W;
  localparam logic [HOST_AW-1:0] A_RCMD = HOST_AW'('h28);
  localparam logic [HOST_AW-1:0] A_RDAT = HOST_AW'('h2C);
  localparam logic [HOST_AW-1:0] A_STAT = HOST_AW'('h30);
  localparam logic [CNT_W-1:0]   CNT_FULL = CNT_W'(FIFO_DEPTH);

  logic [ENT_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  fcnt;
  logic              ovf_flag;
  logic              rd_busy;
  logic [SLV_AW-1:0] rd_cmd;
  logic [DATA_W-1:0] rd_data;
  logic [ECHO_W-1:0] rd_echo;

  logic [31:0]       haddr32;
  logic              win_hit, full, empty, push, pop, rd_accept;
  logic [SLV_AW-1:0] woff;
  logic [ECHO_W-1:0] echo_nx;

  assign haddr32   = 32'(hst_addr);
  assign win_hit   = hst_we && (haddr32 >= 32'(WIN_BASE)) && (haddr32 < 32'(WIN_BASE + WIN_SIZE));
  assign woff      = SLV_AW'(haddr32 - 32'(WIN_BASE));
  assign full      = (fcnt == CNT_FULL);
  assign empty     = (fcnt == '0);
  assign push      = win_hit && !full;
  assign pop       = be_req && be_ack && be_wr;
  assign rd_accept = hst_we && (hst_addr == A_RCMD) && !rd_busy && (hst_wdata < 32'(WIN_SIZE));
  assign echo_nx   = NEW_MODE ? rd_cmd[ECHO_W+1:2] : rd_cmd[ECHO_W-1:0];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= {woff, hst_wdata[DATA_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      fcnt     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      fcnt <= fcnt + 1'b1;
      else if (pop && !push) fcnt <= fcnt - 1'b1;
      if (win_hit && full) ovf_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_req   <= 1'b0;
      be_wr    <= 1'b0;
      be_addr  <= '0;
      be_wdata <= '0;
      rd_busy  <= 1'b0;
      rd_cmd   <= '0;
      rd_data  <= '0;
      rd_echo  <= '0;
    end else begin
      if (be_req) begin
        if (be_ack) begin
          be_req <= 1'b0;
          if (!be_wr) begin
            rd_busy <= 1'b0;
            rd_data <= be_rdata;
            rd_echo <= echo_nx;
          end
        end
      end else if (!empty) begin
        be_req              <= 1'b1;
        be_wr               <= 1'b1;
        {be_addr, be_wdata} <= mem[rp];
      end else if (rd_busy) begin
        be_req  <= 1'b1;
        be_wr   <= 1'b0;
        be_addr <= rd_cmd;
      end
      if (rd_accept) begin
        rd_busy <= 1'b1;
        rd_cmd  <= hst_wdata[SLV_AW-1:0];
      end
    end
  end

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      A_RCMD:  hst_rdata = 32'(rd_cmd);
      A_RDAT:  hst_rdata = {rd_busy, rd_echo, rd_data};
      A_STAT:  hst_rdata = (32'(ovf_flag) << 12) | (32'(full) << 11) | (32'(empty) << 10);
      default: hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk #(
  parameter int HOST_AW    = 16,
  parameter int WIN_SIZE   = 4096,
  parameter int FIFO_DEPTH = 4,
  parameter int SLV_AW     = 17,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hst_we,
  input logic [HOST_AW-1:0] hst_addr,
  input logic [31:0]        hst_wdata,
  input logic               be_req,
  input logic               be_wr,
  input logic [SLV_AW-1:0]  be_addr,
  input logic [DATA_W-1:0]  be_wdata,
  input logic               be_ack,
  input logic               busy,
  input logic [CNT_W-1:0]   cnt,
  input logic               ovf
);
  logic cmd_wr;
  assign cmd_wr = hst_we && (hst_addr == HOST_AW'('h28));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_ack |=> be_req && $stable(be_wr) && $stable(be_addr) && $stable(be_wdata));

  p_gap_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack |=> !be_req);

  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && (hst_wdata < 32'(WIN_SIZE)) |=> busy);

  p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack && !be_wr |=> !busy);

  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && (hst_wdata >= 32'(WIN_SIZE)) |=> !busy);

  p_read_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) && !be_wr |-> cnt == '0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FIFO_DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind pmic_bridge pmic_bridge_chk #(
  .HOST_AW(HOST_AW), .WIN_SIZE(WIN_SIZE), .FIFO_DEPTH(FIFO_DEPTH),
  .SLV_AW(SLV_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
  .be_req(be_req), .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack),
  .busy(rd_busy), .cnt(fcnt), .ovf(ovf_flag)
);

// File: tb/pmic_bridge_tb_top.sv
module pmic_bridge_tb_top;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        hst_we = 1'b0;
  logic [15:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] rd0, rd1;
  logic        be_req, be_wr, be_ack = 1'b0;
  logic [16:0] be_addr;
  logic [15:0] be_wdata, be_rdata;
  logic        n_req, n_wr;
  logic [16:0] n_addr;
  logic [15:0] n_wdata, n_rdata;

  assign be_rdata = be_addr[15:0] ^ 16'h5A3C;
  assign n_rdata  = n_addr[15:0] ^ 16'h5A3C;

  pmic_bridge #(.FIFO_DEPTH(DEPTH), .NEW_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(rd0), .be_req(be_req), .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_ack(be_ack), .be_rdata(be_rdata));

  pmic_bridge #(.FIFO_DEPTH(DEPTH), .NEW_MODE(1'b1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(rd1), .be_req(n_req), .be_wr(n_wr), .be_addr(n_addr), .be_wdata(n_wdata),
    .be_ack(be_ack), .be_rdata(n_rdata));

  int checks = 0, fails = 0;
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // back-end responder
  int ack_lat = 0, wc = 0;
  always @(negedge clk) begin
    if (!be_req) begin be_ack = 1'b0; wc = 0; end
    else if (wc >= ack_lat) be_ack = 1'b1;
    else begin wc++; be_ack = 1'b0; end
  end

  // completed transaction log: {wr, addr, data}
  logic [33:0] done_log[$];
  always @(posedge clk)
    if (rst_n && be_req && be_ack) done_log.push_back({be_wr, be_addr, be_wdata});

  // behavioural reference model
  bit          m_req, m_wr, m_busy, m_ovf;
  logic [16:0] m_addr, m_cmd;
  logic [15:0] m_wd, m_data;
  logic [14:0] m_echo, m_echo_n;
  logic [32:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_wr = 0; m_busy = 0; m_ovf = 0;
      m_addr = '0; m_cmd = '0; m_wd = '0; m_data = '0; m_echo = '0; m_echo_n = '0;
      q.delete();
    end else begin
      bit pre_full, pre_empty, pre_busy;
      int a;
      pre_full  = (q.size() == DEPTH);
      pre_empty = (q.size() == 0);
      pre_busy  = m_busy;
      if (m_req) begin
        if (be_ack) begin
          m_req = 0;
          if (m_wr) void'(q.pop_front());
          else begin
            m_busy = 0; m_data = m_addr[15:0] ^ 16'h5A3C;
            m_echo = m_cmd[14:0]; m_echo_n = m_cmd[16:2];
          end
        end
      end else if (!pre_empty) begin
        m_req = 1; m_wr = 1; {m_addr, m_wd} = q[0];
      end else if (pre_busy) begin
        m_req = 1; m_wr = 0; m_addr = m_cmd;
      end
      if (hst_we) begin
        a = int'(hst_addr);
        if (a == 'h28 && !pre_busy && hst_wdata < 32'd4096) begin
          m_busy = 1; m_cmd = hst_wdata[16:0];
        end
        if (a >= 'h8000 && a < 'h9000) begin
          if (pre_full) m_ovf = 1;
          else q.push_back({17'(a - 'h8000), hst_wdata[15:0]});
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R9", "be_req", 32'(be_req), 32'(m_req));
      chk("R4", "second instance be_req", 32'(n_req), 32'(m_req));
      if (m_req) begin
        chk("R9", "be_wr", 32'(be_wr), 32'(m_wr));
        chk("R6", "be_addr", 32'(be_addr), 32'(m_addr));
        if (m_wr) chk("R6", "be_wdata", 32'(be_wdata), 32'(m_wd));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk); hst_addr = a; #1; v0 = rd0; v1 = rd1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!m_req && !m_busy && q.size() == 0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(16'h30, v0, v1); chk("R1", "status after reset", v0, 32'h400);
    rd(16'h2C, v0, v1); chk("R1", "read data after reset", v0, 32'h0);
    chk("R1", "be_req after reset", 32'(be_req), 32'h0);

    // R2 / R3 / R4 basic read
    ack_lat = 3;
    wr(16'h28, 32'h0ABC);
    rd(16'h2C, v0, v1); chk("R2", "busy after command", 32'(v0[31]), 32'h1);
    wait_idle();
    rd(16'h2C, v0, v1);
    chk("R3", "read result old mode", v0, {1'b0, 15'h0ABC, 16'h0ABC ^ 16'h5A3C});
    chk("R4", "echo new mode", 32'(v1[30:16]), 32'h2AF);

    // R5 out of range and upper boundary
    done_log.delete();
    wr(16'h28, 32'h1000);
    rd(16'h2C, v0, v1); chk("R5", "busy on out-of-range", 32'(v0[31]), 32'h0);
    repeat (6) @(negedge clk);
    chk("R5", "no transaction on out-of-range", 32'(done_log.size()), 32'h0);
    ack_lat = 0;
    wr(16'h28, 32'h0FFF);
    wait_idle();
    rd(16'h2C, v0, v1);
    chk("R5", "boundary address accepted", v0, {1'b0, 15'h0FFF, 16'h0FFF ^ 16'h5A3C});
    chk("R4", "boundary echo new mode", 32'(v1[30:16]), 32'h3FF);

    // R11 command while busy
    ack_lat = 8;
    wr(16'h28, 32'h0124);
    wr(16'h28, 32'h0200);
    rd(16'h28, v0, v1); chk("R11", "pending command kept", v0, 32'h124);
    wait_idle();
    rd(16'h2C, v0, v1); chk("R11", "result from first command", v0, {1'b0, 15'h0124, 16'h0124 ^ 16'h5A3C});

    // R7 / R8 full and overflow
    done_log.delete();
    ack_lat = 10;
    wr(16'h8004, 32'h1111);
    wr(16'h8008, 32'h2222);
    rd(16'h30, v0, v1); chk("R7", "status full", v0, 32'h800);
    wr(16'h8010, 32'h3333);
    rd(16'h30, v0, v1); chk("R8", "overflow flag while full", v0, 32'h1800);
    wait_idle();
    rd(16'h30, v0, v1); chk("R8", "overflow sticky after drain", v0, 32'h1400);
    chk("R8", "dropped write not issued", 32'(done_log.size()), 32'h2);
    if (done_log.size() == 2)
      chk("R6", "second write order", 32'(done_log[1]), 32'({1'b1, 17'h8, 16'h2222}));

    // R10 read waits for queued writes; R6 window edges
    done_log.delete();
    ack_lat = 2;
    wr(16'h8100, 32'hAAAA);
    wr(16'h28, 32'h0040);
    wait_idle();
    chk("R10", "transactions completed", 32'(done_log.size()), 32'h2);
    if (done_log.size() == 2) begin
      chk("R10", "write completes first", 32'(done_log[0][33]), 32'h1);
      chk("R10", "read completes second", 32'(done_log[1][33]), 32'h0);
    end
    done_log.delete();
    wr(16'h7FFC, 32'h5555);
    wr(16'h9000, 32'h6666);
    wr(16'h8FFC, 32'h7777);
    wait_idle();
    chk("R6", "only in-window store issued", 32'(done_log.size()), 32'h1);
    if (done_log.size() == 1)
      chk("R6", "top of window", 32'(done_log[0]), 32'({1'b1, 17'hFFC, 16'h7777}));

    // R1 / R8 reset clears overflow
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(16'h30, v0, v1); chk("R8", "reset clears overflow", v0, 32'h400);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule